// File: doc/BRIEF.md
# Bus Master Exclusive-Access Lock Sequencer

This block controls the shared LOCK# line of a PCI bus master that runs exclusive (locked) sequences against a target. Local logic sends it commands over a valid/ready handshake. A start command opens a sequence with a read. A continue command runs another locked transaction while the lock is held. A finish command closes the sequence. The master's transaction engine supplies the phase and termination indications. From these the block decides, clock by clock, whether LOCK# is driven high, driven low, or released to high impedance.

The engine raises `addr_next` in the cycle before it drives an address phase. In that address phase LOCK# is driven high. In the cycle after it, LOCK# goes low, for the first transaction and for every continuation. The sequence counts as held once a data phase of the first transaction completes. LOCK# then stays low between transactions. A retry of the first transaction before any data moves drops the attempt, and so does a master-abort or target-abort. A finish command issued during the last transaction is deferred: LOCK# is released only after IRDY# has gone inactive. Every release drives LOCK# high for one cycle before the output enable falls. Three status flags report the outcome: held, failed on retry, and aborted.

Top module: `pci_lock_seq`

## Requirements
- R1: After a synchronous reset, `lock_oe` is 0, `lock_n_o` is 1, `lock_held`, `lock_failed`, `lock_aborted` and `cmd_rejected` are 0, and `cmd_ready` is 1.
- R2: An accepted start command (`cmd_op`=0) with `cmd_read`=1 enables the LOCK# driver at the high level. When `addr_next` is seen, LOCK# stays high through the following address-phase cycle and is driven low from the cycle after it.
- R3: A start command with `cmd_read`=0, a continue command (`cmd_op`=1) or finish command (`cmd_op`=2) while no lock is held, or any command not legal in the current state is consumed and rejected. `cmd_rejected` pulses for one cycle and LOCK# and the status flags do not change.
- R4: `lock_held` rises in the cycle after a data phase of the first transaction completes (IRDY# and TRDY# both low in the same cycle), and not before.
- R5: If `term_retry` arrives during the first transaction before any data phase has completed, `lock_failed` is set, `lock_held` stays 0 and LOCK# is released.
- R6: `term_mabort` or `term_tabort` during any locked transaction sets `lock_aborted`, clears `lock_held` and releases LOCK#.
- R7: While a lock is held, LOCK# stays low between transactions and after a retried continuation. A continue command keeps it low until the next address phase, drives it high in that phase, and drives it low again in the cycle after.
- R8: A finish command accepted during a transaction defers the release until FRAME# and IRDY# are both high. A finish command accepted between transactions releases LOCK# at once.
- R9: A release drives LOCK# high with the driver enabled for exactly one cycle. The driver is then disabled.
- R10: An accepted start command clears `lock_failed` and `lock_aborted`.
- R11: `cmd_ready` is 1 when idle, when held between transactions, and during a held transaction until a finish is pending. It is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command valid |
| cmd_op | input | 2 | 0 start, 1 continue, 2 finish |
| cmd_read | input | 1 | Start command carries a read (required) |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_rejected | output | 1 | One-cycle pulse after a consumed illegal command |
| addr_next | input | 1 | Engine drives an address phase in the next cycle |
| frame_n | input | 1 | FRAME# as seen on the bus |
| irdy_n | input | 1 | IRDY# as seen on the bus |
| trdy_n | input | 1 | TRDY# as seen on the bus |
| term_retry | input | 1 | Current transaction is being retried |
| term_mabort | input | 1 | Current transaction ended in master-abort |
| term_tabort | input | 1 | Current transaction ended in target-abort |
| lock_n_o | output | 1 | LOCK# output level |
| lock_oe | output | 1 | LOCK# output enable |
| lock_held | output | 1 | Exclusive access established |
| lock_failed | output | 1 | First transaction retried without data |
| lock_aborted | output | 1 | Sequence ended by an abort |

## Verification
Every output is a register, or a decode of registers in the case of `cmd_ready`, and each one answers a stimulus after exactly one rising edge. The bench drives each stimulus on a falling edge and compares all seven outputs on the next falling edge. LOCK# therefore goes low two samples after `addr_next`: one sample shows the address phase high and the next shows it low. A release shows one sample with the pin high and still enabled, then one with the driver off. A deferred finish shows LOCK# still low through the data phase, then high in the sample after IRDY# rises.

// File: rtl/pci_lock_pkg.sv
package pci_lock_pkg;
  localparam int OP_W = 2;
  localparam int ST_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_START = 2'd0,
    OP_CONT  = 2'd1,
    OP_FIN   = 2'd2
  } lk_op_e;

  typedef enum logic [ST_W-1:0] {
    ST_IDLE = 3'd0,
    ST_ARM  = 3'd1,
    ST_ADR  = 3'd2,
    ST_XFER = 3'd3,
    ST_HOLD = 3'd4,
    ST_PARK = 3'd5
  } lk_state_e;
endpackage

// File: rtl/pci_lock_cmd.sv
module pci_lock_cmd
  import pci_lock_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            cmd_valid,
  input  logic [OP_W-1:0] cmd_op,
  input  logic            cmd_read,
  input  lk_state_e       st_q,
  input  logic            held_q,
  input  logic            fin_q,
  output logic            cmd_ready,
  output logic            acc_start,
  output logic            acc_cont,
  output logic            acc_fin,
  output logic            rej_q
);
  logic hs, reject;

  always_comb begin
    cmd_ready = (st_q == ST_IDLE) || (st_q == ST_HOLD) ||
                (st_q == ST_XFER && held_q && !fin_q);
    hs        = cmd_valid && cmd_ready;
    acc_start = hs && cmd_op == OP_START && cmd_read && st_q == ST_IDLE;
    acc_cont  = hs && cmd_op == OP_CONT && st_q == ST_HOLD;
    acc_fin   = hs && cmd_op == OP_FIN && held_q &&
                (st_q == ST_HOLD || st_q == ST_XFER);
    reject    = hs && !acc_start && !acc_cont && !acc_fin;
  end

  always_ff @(posedge clk) begin
    if (rst) rej_q <= 1'b0;
    else     rej_q <= reject;
  end

  assert_reject_only_on_handshake_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && rej_q) |-> $past(cmd_valid && cmd_ready));
endmodule

// File: rtl/pci_lock_fsm.sv
module pci_lock_fsm
  import pci_lock_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      acc_start,
  input  logic      acc_cont,
  input  logic      acc_fin,
  input  logic      addr_next,
  input  logic      frame_n,
  input  logic      irdy_n,
  input  logic      trdy_n,
  input  logic      term_retry,
  input  logic      term_mabort,
  input  logic      term_tabort,
  output lk_state_e st_q,
  output lk_state_e st_d,
  output logic      held_q,
  output logic      failed_q,
  output logic      aborted_q,
  output logic      fin_q
);
  logic held_d, failed_d, aborted_d, fin_d;
  logic first_q, first_d, done_q, done_d;
  logic data_now, bus_end, abort;

  always_comb begin
    data_now  = !irdy_n && !trdy_n;
    bus_end   = frame_n && irdy_n;
    abort     = term_mabort || term_tabort;
    st_d      = st_q;
    held_d    = held_q;
    failed_d  = failed_q;
    aborted_d = aborted_q;
    fin_d     = fin_q;
    first_d   = first_q;
    done_d    = done_q;
    case (st_q)
      ST_IDLE: if (acc_start) begin
        st_d = ST_ARM; held_d = 1'b0; failed_d = 1'b0; aborted_d = 1'b0;
        fin_d = 1'b0; first_d = 1'b1; done_d = 1'b0;
      end
      ST_ARM: if (addr_next) st_d = ST_ADR;
      ST_ADR: st_d = ST_XFER;
      ST_XFER: begin
        fin_d = fin_q || acc_fin;
        if (abort) begin
          st_d = ST_PARK; held_d = 1'b0; aborted_d = 1'b1; fin_d = 1'b0;
        end else if (term_retry && first_q && !done_q && !data_now) begin
          st_d = ST_PARK; failed_d = 1'b1; fin_d = 1'b0;
        end else if (bus_end) begin
          first_d = 1'b0;
          if (fin_q || acc_fin || !held_q) begin
            st_d = ST_PARK; held_d = 1'b0; fin_d = 1'b0;
            if (!held_q) failed_d = 1'b1;
          end else begin
            st_d = ST_HOLD;
          end
        end else if (data_now) begin
          done_d = 1'b1;
          if (first_q) held_d = 1'b1;
        end
      end
      ST_HOLD: begin
        if (acc_cont) begin
          st_d = ST_ARM; first_d = 1'b0; done_d = 1'b0;
        end else if (acc_fin) begin
          st_d = ST_PARK; held_d = 1'b0;
        end
      end
      ST_PARK: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= ST_IDLE; held_q <= 1'b0; failed_q <= 1'b0; aborted_q <= 1'b0;
      fin_q <= 1'b0; first_q <= 1'b0; done_q <= 1'b0;
    end else begin
      st_q <= st_d; held_q <= held_d; failed_q <= failed_d; aborted_q <= aborted_d;
      fin_q <= fin_d; first_q <= first_d; done_q <= done_d;
    end
  end

  assert_held_after_data_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(held_q) |-> $past(!irdy_n && !trdy_n));

  assert_retry_release_R5: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_XFER && first_q && !done_q && term_retry && !(!irdy_n && !trdy_n)
     && !term_mabort && !term_tabort) |=> (failed_q && !held_q && st_q == ST_PARK));

  assert_abort_release_R6: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_XFER && (term_mabort || term_tabort)) |=>
    (aborted_q && !held_q && st_q == ST_PARK));

  assert_finish_waits_R8: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_XFER && fin_q && !(frame_n && irdy_n) && !term_mabort && !term_tabort)
    |=> (st_q == ST_XFER));
endmodule

// File: rtl/pci_lock_pin.sv
module pci_lock_pin
  import pci_lock_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  lk_state_e st_d,
  input  lk_state_e st_q,
  output logic      lock_n_q,
  output logic      oe_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      lock_n_q <= 1'b1;
      oe_q     <= 1'b0;
    end else begin
      oe_q <= (st_d != ST_IDLE);
      if (st_d == ST_XFER || st_d == ST_HOLD) lock_n_q <= 1'b0;
      else if (st_d != ST_ARM)                lock_n_q <= 1'b1;
    end
  end

  assert_addr_phase_high_R2: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_ADR) |-> (lock_n_q && oe_q));

  assert_low_only_driven_R7: assert property (@(posedge clk) disable iff (rst)
    !lock_n_q |-> oe_q);

  assert_float_after_high_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $fell(oe_q)) |-> $past(lock_n_q));
endmodule

// File: rtl/pci_lock_seq.sv
module pci_lock_seq
  import pci_lock_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            cmd_valid,
  input  logic [OP_W-1:0] cmd_op,
  input  logic            cmd_read,
  output logic            cmd_ready,
  output logic            cmd_rejected,
  input  logic            addr_next,
  input  logic            frame_n,
  input  logic            irdy_n,
  input  logic            trdy_n,
  input  logic            term_retry,
  input  logic            term_mabort,
  input  logic            term_tabort,
  output logic            lock_n_o,
  output logic            lock_oe,
  output logic            lock_held,
  output logic            lock_failed,
  output logic            lock_aborted
);
  lk_state_e st_q, st_d;
  logic      fin_q, acc_start, acc_cont, acc_fin;

  pci_lock_cmd u_cmd (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_read(cmd_read),
    .st_q(st_q), .held_q(lock_held), .fin_q(fin_q), .cmd_ready(cmd_ready),
    .acc_start(acc_start), .acc_cont(acc_cont), .acc_fin(acc_fin), .rej_q(cmd_rejected)
  );

  pci_lock_fsm u_fsm (
    .clk(clk), .rst(rst), .acc_start(acc_start), .acc_cont(acc_cont), .acc_fin(acc_fin),
    .addr_next(addr_next), .frame_n(frame_n), .irdy_n(irdy_n), .trdy_n(trdy_n),
    .term_retry(term_retry), .term_mabort(term_mabort), .term_tabort(term_tabort),
    .st_q(st_q), .st_d(st_d), .held_q(lock_held), .failed_q(lock_failed),
    .aborted_q(lock_aborted), .fin_q(fin_q)
  );

  pci_lock_pin u_pin (
    .clk(clk), .rst(rst), .st_d(st_d), .st_q(st_q), .lock_n_q(lock_n_o), .oe_q(lock_oe)
  );
endmodule

// File: tb/pci_lock_seq_tb.sv
module pci_lock_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 33;
  // vector: {req[3:0], cv, op[1:0], rd, an, fr, ir, tr, rt, ma, ta, exp[6:0]}
  // exp   : {lock_n, oe, held, failed, aborted, rejected, ready}
  localparam logic [21:0] VEC [NV] = '{
    {4'd1,  11'b0_00_0_0_111_000, 7'b1_0_0_0_0_0_1}, // R1 idle
    {4'd2,  11'b1_00_1_0_111_000, 7'b1_1_0_0_0_0_0}, // R2 start read
    {4'd2,  11'b0_00_0_1_111_000, 7'b1_1_0_0_0_0_0}, // R2 addr next
    {4'd2,  11'b0_00_0_0_011_000, 7'b0_1_0_0_0_0_0}, // R2 after addr phase low
    {4'd4,  11'b0_00_0_0_100_000, 7'b0_1_1_0_0_0_1}, // R4 data done, R11 ready
    {4'd7,  11'b0_00_0_0_111_000, 7'b0_1_1_0_0_0_1}, // R7 between transactions
    {4'd7,  11'b0_00_0_0_111_000, 7'b0_1_1_0_0_0_1}, // R7
    {4'd7,  11'b1_01_0_0_111_000, 7'b0_1_1_0_0_0_0}, // R7 continue keeps low
    {4'd7,  11'b0_00_0_1_111_000, 7'b1_1_1_0_0_0_0}, // R7 addr phase high
    {4'd7,  11'b0_00_0_0_011_000, 7'b0_1_1_0_0_0_1}, // R7 low again
    {4'd8,  11'b1_10_0_0_001_000, 7'b0_1_1_0_0_0_0}, // R8 finish deferred, R11
    {4'd8,  11'b0_00_0_0_100_000, 7'b0_1_1_0_0_0_0}, // R8 last data
    {4'd8,  11'b0_00_0_0_111_000, 7'b1_1_0_0_0_0_0}, // R8 irdy high -> release
    {4'd9,  11'b0_00_0_0_111_000, 7'b1_0_0_0_0_0_1}, // R9 float
    {4'd3,  11'b1_00_0_0_111_000, 7'b1_0_0_0_0_1_1}, // R3 start write
    {4'd3,  11'b0_00_0_0_111_000, 7'b1_0_0_0_0_0_1}, // R3 pulse ends
    {4'd3,  11'b1_10_0_0_111_000, 7'b1_0_0_0_0_1_1}, // R3 finish idle
    {4'd2,  11'b1_00_1_0_111_000, 7'b1_1_0_0_0_0_0}, // R2
    {4'd2,  11'b0_00_0_1_111_000, 7'b1_1_0_0_0_0_0}, // R2
    {4'd2,  11'b0_00_0_0_011_000, 7'b0_1_0_0_0_0_0}, // R2
    {4'd5,  11'b0_00_0_0_101_100, 7'b1_1_0_1_0_0_0}, // R5 retry first
    {4'd5,  11'b0_00_0_0_111_000, 7'b1_0_0_1_0_0_1}, // R5
    {4'd10, 11'b1_00_1_0_111_000, 7'b1_1_0_0_0_0_0}, // R10 failed cleared
    {4'd2,  11'b0_00_0_1_111_000, 7'b1_1_0_0_0_0_0}, // R2
    {4'd2,  11'b0_00_0_0_011_000, 7'b0_1_0_0_0_0_0}, // R2
    {4'd4,  11'b0_00_0_0_100_000, 7'b0_1_1_0_0_0_1}, // R4
    {4'd7,  11'b0_00_0_0_111_000, 7'b0_1_1_0_0_0_1}, // R7
    {4'd7,  11'b1_01_0_0_111_000, 7'b0_1_1_0_0_0_0}, // R7
    {4'd7,  11'b0_00_0_1_111_000, 7'b1_1_1_0_0_0_0}, // R7
    {4'd7,  11'b0_00_0_0_011_000, 7'b0_1_1_0_0_0_1}, // R7
    {4'd6,  11'b0_00_0_0_001_001, 7'b1_1_0_0_1_0_0}, // R6 target abort
    {4'd6,  11'b0_00_0_0_111_000, 7'b1_0_0_0_1_0_1}, // R6
    {4'd3,  11'b1_01_0_0_111_000, 7'b1_0_0_0_1_1_1}  // R3 continue idle
  };

  logic clk = 1'b0, rst = 1'b1;
  logic cmd_valid = 1'b0, cmd_read = 1'b0, addr_next = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic frame_n = 1'b1, irdy_n = 1'b1, trdy_n = 1'b1;
  logic term_retry = 1'b0, term_mabort = 1'b0, term_tabort = 1'b0;
  logic cmd_ready, cmd_rejected, lock_n_o, lock_oe, lock_held, lock_failed, lock_aborted;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pci_lock_seq u_dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_read(cmd_read),
    .cmd_ready(cmd_ready), .cmd_rejected(cmd_rejected), .addr_next(addr_next),
    .frame_n(frame_n), .irdy_n(irdy_n), .trdy_n(trdy_n), .term_retry(term_retry),
    .term_mabort(term_mabort), .term_tabort(term_tabort), .lock_n_o(lock_n_o),
    .lock_oe(lock_oe), .lock_held(lock_held), .lock_failed(lock_failed),
    .lock_aborted(lock_aborted)
  );

  function automatic logic [6:0] obs();
    return {lock_n_o, lock_oe, lock_held, lock_failed, lock_aborted, cmd_rejected, cmd_ready};
  endfunction

  task automatic check(input logic [3:0] req, input logic [6:0] exp);
    checks++;
    if (obs() !== exp) begin
      errors++;
      $display("FAIL R%0d at %0t: got %b expected %b", req, $time, obs(), exp);
    end
  endtask

  // drive at falling edge, one rising edge, compare at next falling edge
  task automatic step(input logic [21:0] v);
    @(negedge clk);
    {cmd_valid, cmd_op, cmd_read, addr_next, frame_n, irdy_n, trdy_n,
     term_retry, term_mabort, term_tabort} = v[17:7];
    @(posedge clk);
    @(negedge clk);
    check(v[21:18], v[6:0]);
    {cmd_valid, addr_next, term_retry, term_mabort, term_tabort} = '0;
  endtask

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(4'd1, 7'b1_0_0_0_0_0_1); // R1 reset state
    rst = 1'b0;
    for (int i = 0; i < NV; i++) step(VEC[i]);
    // R6 master abort on the first transaction; R10 aborted cleared by start
    step({4'd10, 11'b1_00_1_0_111_000, 7'b1_1_0_0_0_0_0});
    step({4'd2,  11'b0_00_0_1_111_000, 7'b1_1_0_0_0_0_0});
    step({4'd2,  11'b0_00_0_0_011_000, 7'b0_1_0_0_0_0_0});
    step({4'd6,  11'b0_00_0_0_111_010, 7'b1_1_0_0_1_0_0});
    step({4'd9,  11'b0_00_0_0_111_000, 7'b1_0_0_0_1_0_1});
    // R8 finish between transactions releases at once
    step({4'd2,  11'b1_00_1_0_111_000, 7'b1_1_0_0_0_0_0});
    step({4'd2,  11'b0_00_0_1_111_000, 7'b1_1_0_0_0_0_0});
    step({4'd2,  11'b0_00_0_0_011_000, 7'b0_1_0_0_0_0_0});
    step({4'd4,  11'b0_00_0_0_100_000, 7'b0_1_1_0_0_0_1});
    step({4'd7,  11'b0_00_0_0_111_000, 7'b0_1_1_0_0_0_1});
    step({4'd8,  11'b1_10_0_0_111_000, 7'b1_1_0_0_0_0_0});
    step({4'd9,  11'b0_00_0_0_111_000, 7'b1_0_0_0_0_0_1});
    // R7 retried continuation keeps the lock
    step({4'd2,  11'b1_00_1_0_111_000, 7'b1_1_0_0_0_0_0});
    step({4'd2,  11'b0_00_0_1_111_000, 7'b1_1_0_0_0_0_0});
    step({4'd2,  11'b0_00_0_0_011_000, 7'b0_1_0_0_0_0_0});
    step({4'd4,  11'b0_00_0_0_100_000, 7'b0_1_1_0_0_0_1});
    step({4'd7,  11'b0_00_0_0_111_000, 7'b0_1_1_0_0_0_1});
    step({4'd7,  11'b1_01_0_0_111_000, 7'b0_1_1_0_0_0_0});
    step({4'd7,  11'b0_00_0_1_111_000, 7'b1_1_1_0_0_0_0});
    step({4'd7,  11'b0_00_0_0_011_000, 7'b0_1_1_0_0_0_1});
    step({4'd7,  11'b0_00_0_0_111_100, 7'b0_1_1_0_0_0_1});
    // R1 reset while a lock is held
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(4'd1, 7'b1_0_0_0_0_0_1);
    rst = 1'b0;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule